// File: doc/BRIEF.md
# Boundary-Scan Chain Strobe Generator

This block sits beside a TAP controller and drives the control lines of an external boundary-scan chain made of master/slave scan cells. On each rising edge of the test clock it samples the TAP state code, the current instruction and the number of the selected scan chain. It registers qualifiers from these values. It then gates the two test-clock phases with those qualifiers to make the strobes: capture pulses for the external-test and internal-test instructions, an update pulse, and a pair of non-overlapping shift clocks. It also produces a cell output-enable, a reset indication, and a retimed copy of the serial test data for the chain.

Every strobe and the output-enable are tied to one designated scan chain number, 3 by default. While any other chain is selected, the external chain sees no activity. The strobes are combinational ANDs of a phase clock with a qualifier that is stable for the whole test-clock period. Each visit to a state therefore gives exactly one clean pulse.

Top module: `bscan_strobe_gen`

## Requirements
- R1: TAP state codes on `tap_state` are Test-Logic-Reset 4'hF, Run-Test/Idle 4'hC, Capture-DR 4'h6, Shift-DR 4'h2, Update-DR 4'h5 and Update-IR 4'hD. Instruction codes are external-test 4'h0, internal-test 4'hC, clamp 4'h5, clamp-high-Z 4'h9 and bypass 4'hF. The cell enable is updated at the rising edge that enters Update-IR: it sets for external-test, internal-test, clamp or clamp-high-Z with chain 3 selected, and clears for any other instruction. It holds its value in every other state.
- R2: `ext_cap` gives one pulse, high only while `ph2` is high, in the cycle after a rising edge that samples Capture-DR with the external-test instruction and chain 3.
- R3: `int_cap` gives one pulse, high only while `ph2` is high, in the cycle after a rising edge that samples Capture-DR with the internal-test instruction and chain 3.
- R4: `upd` gives one pulse, high only while `ph2` is high, in the cycle after a rising edge that samples Update-DR with chain 3, whatever the instruction.
- R5: `rst_ind` is high whenever `trst_n` is low, and for the cycle after a rising edge that samples Test-Logic-Reset.
- R6: In the cycle after a rising edge that samples Shift-DR with chain 3, `shclk_m` follows `ph1` and `shclk_s` follows `ph2`. Both are low otherwise, and they are never high together.
- R7: While the chain sampled at the last rising edge is not 3, all strobes and `cell_oe` are low. This includes Shift-DR, Capture-DR and Update-DR of other chains.
- R8: `rst` is synchronous and active high. It clears all strobes and the cell enable, and it sets the reset indication.
- R9: The cell enable is cleared at any rising edge that samples Test-Logic-Reset or `trst_n` low.
- R10: `scan_do` takes `scan_di` at each rising edge of `tck`, so it is stable across the falling edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| trst_n | input | 1 | Active-low test reset |
| ph1 | input | 1 | Clock phase high while tck is high |
| ph2 | input | 1 | Clock phase high while tck is low |
| tap_state | input | 4 | TAP state code entered at the coming rising edge |
| instr | input | 4 | Current instruction |
| chain | input | 5 | Selected scan chain number |
| scan_di | input | 1 | Serial test data from the TAP |
| cell_oe | output | 1 | Boundary cell output-enable |
| ext_cap | output | 1 | External-test capture strobe |
| int_cap | output | 1 | Internal-test capture strobe |
| upd | output | 1 | Update strobe |
| rst_ind | output | 1 | Reset indication for the cells |
| shclk_m | output | 1 | Master shift clock |
| shclk_s | output | 1 | Slave shift clock |
| scan_do | output | 1 | Retimed serial data to the chain |

## Verification
The assertions assume that `ph1` equals `tck` and `ph2` is its inverse. They also assume that `tap_state`, `instr` and `chain` change only while `tck` is low, so the value sampled at one rising edge decides the pulses of the whole period that follows. The bench derives both phases from its own clock with continuous assignments. It changes every input shortly after a falling edge, and it samples outputs in the middle of each phase.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  localparam int ST_W = 4;
  typedef logic [ST_W-1:0] tap_st_t;

  localparam tap_st_t ST_TLR    = 4'hF;
  localparam tap_st_t ST_RTI    = 4'hC;
  localparam tap_st_t ST_CAP_DR = 4'h6;
  localparam tap_st_t ST_SH_DR  = 4'h2;
  localparam tap_st_t ST_UPD_DR = 4'h5;
  localparam tap_st_t ST_UPD_IR = 4'hD;

  typedef struct packed {
    logic tlr;
    logic capx;
    logic capi;
    logic upd;
    logic shift;
  } qual_t;
endpackage

// File: rtl/bsg_decode.sv
module bsg_decode
  import bsg_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int CH_W = 5,
  parameter logic [CH_W-1:0] BS_CHAIN = 5'd3,
  parameter logic [IR_W-1:0] I_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] I_INTEST = 4'hC,
  parameter logic [IR_W-1:0] I_CLAMP  = 4'h5,
  parameter logic [IR_W-1:0] I_CLAMPZ = 4'h9
) (
  input  tap_st_t         tap_state,
  input  logic [IR_W-1:0] instr,
  input  logic [CH_W-1:0] chain,
  output qual_t           nxt,
  output logic            chain_hit,
  output logic            oe_load,
  output logic            oe_val
);
  logic drives_pins;

  always_comb begin
    chain_hit   = (chain == BS_CHAIN);
    drives_pins = (instr == I_EXTEST) || (instr == I_INTEST) ||
                  (instr == I_CLAMP)  || (instr == I_CLAMPZ);
    nxt.tlr   = (tap_state == ST_TLR);
    nxt.capx  = chain_hit && (tap_state == ST_CAP_DR) && (instr == I_EXTEST);
    nxt.capi  = chain_hit && (tap_state == ST_CAP_DR) && (instr == I_INTEST);
    nxt.upd   = chain_hit && (tap_state == ST_UPD_DR);
    nxt.shift = chain_hit && (tap_state == ST_SH_DR);
    oe_load   = (tap_state == ST_UPD_IR);
    oe_val    = chain_hit && drives_pins;
  end
endmodule

// File: rtl/bsg_qual_reg.sv
module bsg_qual_reg
  import bsg_pkg::*;
(
  input  logic  tck,
  input  logic  rst,
  input  logic  trst_n,
  input  qual_t nxt,
  input  logic  chain_hit,
  input  logic  oe_load,
  input  logic  oe_val,
  input  logic  scan_di,
  output qual_t q,
  output logic  hit_q,
  output logic  oe_q,
  output logic  sdo_q
);
  always_ff @(posedge tck) begin
    if (rst) begin
      q       <= '0;
      q.tlr   <= 1'b1;
      hit_q   <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      q     <= nxt;
      hit_q <= chain_hit;
      sdo_q <= scan_di;
      if (!trst_n || nxt.tlr)
        oe_q <= 1'b0;
      else if (oe_load)
        oe_q <= oe_val;
    end
  end
endmodule

// File: rtl/bsg_phase_gate.sv
module bsg_phase_gate #(
  parameter int N = 5
) (
  input  logic [N-1:0] qual,
  input  logic [N-1:0] phase,
  output logic [N-1:0] strobe
);
  for (genvar i = 0; i < N; i++) begin : g_and
    assign strobe[i] = qual[i] & phase[i];
  end
endmodule

// File: rtl/bscan_strobe_gen.sv
module bscan_strobe_gen
  import bsg_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int CH_W = 5,
  parameter logic [CH_W-1:0] BS_CHAIN = 5'd3,
  parameter logic [IR_W-1:0] I_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] I_INTEST = 4'hC,
  parameter logic [IR_W-1:0] I_CLAMP  = 4'h5,
  parameter logic [IR_W-1:0] I_CLAMPZ = 4'h9
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            trst_n,
  input  logic            ph1,
  input  logic            ph2,
  input  logic [3:0]      tap_state,
  input  logic [IR_W-1:0] instr,
  input  logic [CH_W-1:0] chain,
  input  logic            scan_di,
  output logic            cell_oe,
  output logic            ext_cap,
  output logic            int_cap,
  output logic            upd,
  output logic            rst_ind,
  output logic            shclk_m,
  output logic            shclk_s,
  output logic            scan_do
);
  localparam int NUM_STROBES = 5;

  qual_t nxt, q;
  logic  chain_hit, oe_load, oe_val, hit_q, oe_q;
  logic [NUM_STROBES-1:0] g_qual, g_phase, g_out;

  bsg_decode #(
    .IR_W(IR_W), .CH_W(CH_W), .BS_CHAIN(BS_CHAIN),
    .I_EXTEST(I_EXTEST), .I_INTEST(I_INTEST),
    .I_CLAMP(I_CLAMP), .I_CLAMPZ(I_CLAMPZ)
  ) u_decode (
    .tap_state (tap_state),
    .instr     (instr),
    .chain     (chain),
    .nxt       (nxt),
    .chain_hit (chain_hit),
    .oe_load   (oe_load),
    .oe_val    (oe_val)
  );

  bsg_qual_reg u_qreg (
    .tck       (tck),
    .rst       (rst),
    .trst_n    (trst_n),
    .nxt       (nxt),
    .chain_hit (chain_hit),
    .oe_load   (oe_load),
    .oe_val    (oe_val),
    .scan_di   (scan_di),
    .q         (q),
    .hit_q     (hit_q),
    .oe_q      (oe_q),
    .sdo_q     (scan_do)
  );

  assign g_qual  = {q.capx, q.capi, q.upd, q.shift, q.shift};
  assign g_phase = {ph2,    ph2,    ph2,   ph1,     ph2};

  bsg_phase_gate #(.N(NUM_STROBES)) u_gate (
    .qual   (g_qual),
    .phase  (g_phase),
    .strobe (g_out)
  );

  assign {ext_cap, int_cap, upd, shclk_m, shclk_s} = g_out;
  assign cell_oe = oe_q & hit_q;
  assign rst_ind = q.tlr | ~trst_n;
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker
  import bsg_pkg::*;
#(
  parameter int IR_W = 4,
  parameter int CH_W = 5,
  parameter logic [CH_W-1:0] BS_CHAIN = 5'd3,
  parameter logic [IR_W-1:0] I_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] I_INTEST = 4'hC
) (
  input logic            tck,
  input logic            rst,
  input logic            trst_n,
  input logic [3:0]      tap_state,
  input logic [IR_W-1:0] instr,
  input logic [CH_W-1:0] chain,
  input logic            cell_oe,
  input logic            ext_cap,
  input logic            int_cap,
  input logic            upd,
  input logic            rst_ind,
  input logic            shclk_m,
  input logic            shclk_s
);
  assert_ext_cap_R2: assert property (@(posedge tck) disable iff (rst)
    ext_cap |-> $past(tap_state == ST_CAP_DR && instr == I_EXTEST && chain == BS_CHAIN));

  assert_int_cap_R3: assert property (@(posedge tck) disable iff (rst)
    int_cap |-> $past(tap_state == ST_CAP_DR && instr == I_INTEST && chain == BS_CHAIN));

  assert_upd_R4: assert property (@(posedge tck) disable iff (rst)
    upd |-> $past(tap_state == ST_UPD_DR && chain == BS_CHAIN));

  assert_trst_R5: assert property (@(posedge tck) disable iff (rst)
    !trst_n |-> rst_ind);

  assert_shift_R6: assert property (@(posedge tck) disable iff (rst)
    shclk_s |-> $past(tap_state == ST_SH_DR && chain == BS_CHAIN));

  assert_no_overlap_R6: assert property (@(posedge tck) disable iff (rst)
    !(shclk_m && shclk_s));

  assert_other_chain_R7: assert property (@(posedge tck) disable iff (rst)
    $past(chain != BS_CHAIN) |-> !cell_oe);

  assert_tlr_clear_R9: assert property (@(posedge tck) disable iff (rst)
    $past(tap_state == ST_TLR || !trst_n) |-> !cell_oe);
endmodule

bind bscan_strobe_gen bsg_checker #(
  .IR_W(IR_W), .CH_W(CH_W), .BS_CHAIN(BS_CHAIN),
  .I_EXTEST(I_EXTEST), .I_INTEST(I_INTEST)
) u_chk (
  .tck(tck), .rst(rst), .trst_n(trst_n), .tap_state(tap_state),
  .instr(instr), .chain(chain), .cell_oe(cell_oe), .ext_cap(ext_cap),
  .int_cap(int_cap), .upd(upd), .rst_ind(rst_ind),
  .shclk_m(shclk_m), .shclk_s(shclk_s)
);

// File: tb/bscan_strobe_gen_bench.sv
module bscan_strobe_gen_bench;
  localparam logic [3:0] S_TLR = 4'hF, S_RTI = 4'hC, S_CAP = 4'h6,
                         S_SH  = 4'h2, S_UDR = 4'h5, S_UIR = 4'hD;
  localparam logic [3:0] I_EXT = 4'h0, I_INT = 4'hC, I_CLP = 4'h5,
                         I_CLZ = 4'h9, I_BYP = 4'hF;

  logic tck = 1'b0;
  logic rst = 1'b1, trst_n = 1'b1, scan_di = 1'b0;
  logic [3:0] tap_state = S_TLR, instr = I_BYP;
  logic [4:0] chain = 5'd0;
  logic ph1, ph2;
  logic cell_oe, ext_cap, int_cap, upd, rst_ind, shclk_m, shclk_s, scan_do;
  logic [7:0] hi_v, lo_v;  // {cell_oe,ext,int,upd,rst_ind,shm,shs,sdo}
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 tck = ~tck;
  assign ph1 = tck;
  assign ph2 = ~tck;

  bscan_strobe_gen u_bscan_strobe_gen (
    .tck(tck), .rst(rst), .trst_n(trst_n), .ph1(ph1), .ph2(ph2),
    .tap_state(tap_state), .instr(instr), .chain(chain), .scan_di(scan_di),
    .cell_oe(cell_oe), .ext_cap(ext_cap), .int_cap(int_cap), .upd(upd),
    .rst_ind(rst_ind), .shclk_m(shclk_m), .shclk_s(shclk_s), .scan_do(scan_do)
  );

  function automatic logic [7:0] snap();
    return {cell_oe, ext_cap, int_cap, upd, rst_ind, shclk_m, shclk_s, scan_do};
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs change just after a falling edge; hi_v is sampled mid high phase,
  // lo_v mid low phase of the period that follows the rising edge.
  task automatic apply(input logic [3:0] st, input logic [3:0] ins, input logic [4:0] ch);
    tap_state = st; instr = ins; chain = ch;
    @(posedge tck); #2; hi_v = snap();
    @(negedge tck); #2; lo_v = snap();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(S_CAP, I_EXT, 5'd3);
    apply(S_SH, I_EXT, 5'd3);
    chk("R8 ext_cap in reset", lo_v[6], 1'b0);
    chk("R8 shclk_m in reset", hi_v[2], 1'b0);
    chk("R8 shclk_s in reset", lo_v[1], 1'b0);
    chk("R8 rst_ind in reset", lo_v[3], 1'b1);
    chk("R8 cell_oe in reset", lo_v[7], 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_extest_capture();
    apply(S_CAP, I_EXT, 5'd3);
    chk("R2 ext_cap low in ph1", hi_v[6], 1'b0);
    chk("R2 ext_cap high in ph2", lo_v[6], 1'b1);
    chk("R3 int_cap quiet on extest", lo_v[5], 1'b0);
    apply(S_SH, I_EXT, 5'd3);
    chk("R2 single ext_cap pulse", lo_v[6], 1'b0);
  endtask

  task automatic t_intest_capture();
    apply(S_CAP, I_INT, 5'd3);
    chk("R3 int_cap low in ph1", hi_v[5], 1'b0);
    chk("R3 int_cap high in ph2", lo_v[5], 1'b1);
    chk("R2 ext_cap quiet on intest", lo_v[6], 1'b0);
    apply(S_RTI, I_INT, 5'd3);
    chk("R3 single int_cap pulse", lo_v[5], 1'b0);
    apply(S_CAP, I_CLP, 5'd3);
    chk("R2 no capture on clamp", lo_v[6], 1'b0);
    chk("R3 no capture on clamp", lo_v[5], 1'b0);
  endtask

  task automatic t_update();
    apply(S_UDR, I_BYP, 5'd3);
    chk("R4 upd low in ph1", hi_v[4], 1'b0);
    chk("R4 upd high in ph2", lo_v[4], 1'b1);
    apply(S_RTI, I_BYP, 5'd3);
    chk("R4 single upd pulse", lo_v[4], 1'b0);
  endtask

  task automatic t_shift();
    for (int k = 0; k < 4; k++) begin
      scan_di = k[0];
      apply(S_SH, I_EXT, 5'd3);
      chk("R6 shclk_m follows ph1", hi_v[2], 1'b1);
      chk("R6 shclk_s low in ph1", hi_v[1], 1'b0);
      chk("R6 shclk_m low in ph2", lo_v[2], 1'b0);
      chk("R6 shclk_s follows ph2", lo_v[1], 1'b1);
      chk("R10 scan_do across fall", lo_v[0], k[0]);
    end
    apply(S_RTI, I_EXT, 5'd3);
    chk("R6 shclk_m idle after shift", hi_v[2], 1'b0);
    chk("R6 shclk_s idle after shift", lo_v[1], 1'b0);
  endtask

  task automatic t_cell_enable();
    logic [3:0] codes [4] = '{I_EXT, I_INT, I_CLP, I_CLZ};
    for (int k = 0; k < 4; k++) begin
      apply(S_UIR, I_BYP, 5'd3);
      chk("R1 cleared by bypass", lo_v[7], 1'b0);
      apply(S_UIR, codes[k], 5'd3);
      chk("R1 set by pin instruction", hi_v[7], 1'b1);
      apply(S_RTI, I_BYP, 5'd3);
      chk("R1 held outside update-IR", lo_v[7], 1'b1);
    end
    apply(S_RTI, I_BYP, 5'd2);
    chk("R7 cell_oe masked off chain", hi_v[7], 1'b0);
    apply(S_RTI, I_BYP, 5'd3);
    chk("R1 enable kept across chain change", hi_v[7], 1'b1);
    apply(S_UIR, I_EXT, 5'd1);
    apply(S_RTI, I_EXT, 5'd3);
    chk("R1 not set with other chain", hi_v[7], 1'b0);
  endtask

  task automatic t_other_chain();
    apply(S_CAP, I_EXT, 5'd2);
    chk("R7 no ext_cap off chain", lo_v[6], 1'b0);
    apply(S_CAP, I_INT, 5'd4);
    chk("R7 no int_cap off chain", lo_v[5], 1'b0);
    apply(S_SH, I_EXT, 5'd0);
    chk("R7 no shclk_m off chain", hi_v[2], 1'b0);
    chk("R7 no shclk_s off chain", lo_v[1], 1'b0);
    apply(S_UDR, I_EXT, 5'd31);
    chk("R7 no upd off chain", lo_v[4], 1'b0);
  endtask

  task automatic t_reset_paths();
    apply(S_UIR, I_EXT, 5'd3);
    apply(S_TLR, I_EXT, 5'd3);
    chk("R5 rst_ind in TLR", hi_v[3], 1'b1);
    chk("R9 TLR clears cell_oe", hi_v[7], 1'b0);
    apply(S_RTI, I_EXT, 5'd3);
    chk("R5 rst_ind drops after TLR", hi_v[3], 1'b0);
    apply(S_UIR, I_CLZ, 5'd3);
    trst_n = 1'b0; #1;
    chk("R5 rst_ind follows trst_n", rst_ind, 1'b1);
    apply(S_RTI, I_CLZ, 5'd3);
    chk("R9 trst_n clears cell_oe", hi_v[7], 1'b0);
    trst_n = 1'b1;
    apply(S_RTI, I_CLZ, 5'd3);
    chk("R5 rst_ind released", hi_v[3], 1'b0);
  endtask

  initial begin
    @(negedge tck); #2;
    t_reset();
    t_extest_capture();
    t_intest_capture();
    t_update();
    t_shift();
    t_cell_enable();
    t_other_chain();
    t_reset_paths();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end
endmodule